// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block collects interrupt causes for a host processor and drives one interrupt line toward it. Hardware event sources pulse bits of a 32-bit cause vector. Each pulse latches into a sticky status word. The host reads that word over a simple register bus and clears individual bits by writing ones to them. A per-bit enable word selects which latched causes may raise the line.

Every ordinary cause is held back by a coalescing timer. The timer starts when the first enabled cause becomes pending, so several events can be gathered into a single interrupt. The timer counts ticks of a prescaler, and one tick stands for 32 microseconds of host time. A parameter sets how many clock cycles make one tick. A dedicated high-priority receive input sets the same status bit as ordinary receive DMA, but it skips the delay. A periodic timer can also post a receive cause at a programmable interval.

The register bus uses a 2-bit word index with a write strobe, and read data is combinational:
- Word 0 is the status word.
- Word 1 is the enable word.
- Word 2 is the timing word. Bits 7:0 hold the coalescing count and bits 15:8 hold the periodic interval.
- Word 3 reads as zero.

Top module: `host_irq_coalescer`

## Requirements
- R1: After reset, the status word and enable word read 0, the timing word reads 0x0000_0040 (coalescing count 0x40, periodic interval 0), word 3 reads 0, and `irq_out` is low.
- R2: A pulse on bit n of `evt_in` sets status bit n at the next clock edge, and the bit stays set while no clear arrives.
- R3: Writing word 0 clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R4: When an event and a write-1 clear hit the same status bit at the same edge, the bit ends up set.
- R5: `irq_out` is high only while some status bit is set whose enable bit (word 1, same position) is also set. A pending cause that is not enabled never raises the line.
- R6: With coalescing count C (word 2, bits 7:0) nonzero, `irq_out` rises exactly C*TICK_CYCLES+1 clock edges after the edge that first makes an enabled cause pending.
- R7: With coalescing count 0, `irq_out` rises one clock edge after an enabled cause becomes pending.
- R8: Further enabled causes arriving while the timer runs do not restart it. Once raised, `irq_out` stays high until every enabled pending cause is cleared. It then drops at that edge, and the next cause starts a new full delay.
- R9: A pulse on `hp_rx` sets status bit 31. If enable bit 31 is set, `irq_out` is high right after that same edge, whatever the coalescing count. An ordinary `evt_in[31]` pulse is still coalesced.
- R10: With periodic interval P (word 2, bits 15:8) nonzero, status bit 28 is set every P ticks (P*TICK_CYCLES clock cycles apart). With P = 0 it is never set by the periodic timer.
- R11: Writes to word 3 have no effect, and reads of word 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word (combinational) |
| evt_in | input | DATA_W | Event pulses, one per status bit |
| hp_rx | input | 1 | High-priority receive event that bypasses coalescing |
| irq_out | output | 1 | Interrupt line to the host |

## Verification
The hardest situation to reach is a second enabled cause landing in the middle of a running coalescing window. Its effect is only visible as the absence of a timer restart. The stimulus holds a short tick, raises one enabled cause, and injects another a few edges later. The bench then samples the line on the edge before and the edge of the expected expiry. Afterward it clears the causes one at a time, so the line must hold through the partial clear and drop on the final one. Finally a fresh cause must pay the full delay again.

// File: rtl/hic_pkg.sv
package hic_pkg;
  // Register word indices on the 2-bit bus address
  localparam logic [1:0] WORD_STATUS = 2'd0;
  localparam logic [1:0] WORD_ENABLE = 2'd1;
  localparam logic [1:0] WORD_TIMING = 2'd2;
  localparam logic [1:0] WORD_SPARE  = 2'd3;

  // Status bit positions with internal sources
  localparam int unsigned BIT_RX_DMA   = 31;  // also set by the bypass input
  localparam int unsigned BIT_PERIODIC = 28;  // periodic receive cause
endpackage

// File: rtl/hic_tick_gen.sv
// Divides clk into one-cycle tick pulses; restart realigns the phase.
module hic_tick_gen #(
  parameter int unsigned TICK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (restart || cnt_q == LAST) cnt_n = '0;
    else                          cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/hic_coalesce_timer.sv
// Arms on the first pending cause, counts down in ticks, then latches expiry
// until nothing is pending.
module hic_coalesce_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic [TW-1:0] coal_val,
  input  logic          tick,
  output logic          load,
  output logic          expired
);
  logic          armed_q, armed_n;
  logic          exp_q, exp_n;
  logic [TW-1:0] cnt_q, cnt_n;

  assign load = pending && !armed_q && !exp_q;

  always_comb begin
    armed_n = armed_q;
    exp_n   = exp_q;
    cnt_n   = cnt_q;
    if (!pending) begin
      armed_n = 1'b0;
      exp_n   = 1'b0;
      cnt_n   = '0;
    end else if (load) begin
      if (coal_val == '0) exp_n = 1'b1;
      else begin
        armed_n = 1'b1;
        cnt_n   = coal_val;
      end
    end else if (armed_q && tick) begin
      if (cnt_q == TW'(1)) begin
        armed_n = 1'b0;
        exp_n   = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_n;
      exp_q   <= exp_n;
      cnt_q   <= cnt_n;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/hic_periodic.sv
// Fires one pulse every 'period' ticks; period 0 holds it idle.
module hic_periodic #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] period,
  input  logic          tick,
  output logic          fire
);
  logic [TW-1:0] cnt_q, cnt_n;
  logic          enabled, at_end;

  assign enabled = (period != '0);
  assign at_end  = (cnt_q >= period - 1'b1);
  assign fire    = enabled && tick && at_end;

  always_comb begin
    cnt_n = cnt_q;
    if (!enabled)   cnt_n = '0;
    else if (tick)  cnt_n = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/host_irq_coalescer.sv
// rst_n is assumed asserted asynchronously and released synchronously upstream.
module host_irq_coalescer
  import hic_pkg::*;
#(
  parameter int unsigned    TICK_CYCLES = 2048,
  parameter int unsigned    DATA_W      = 32,
  parameter int unsigned    TW          = 8,
  parameter logic [TW-1:0]  COAL_RESET  = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_in,
  input  logic              hp_rx,
  output logic              irq_out
);
  localparam int unsigned PAD_W = DATA_W - 2 * TW;

  logic [DATA_W-1:0] status_q, status_n;
  logic [DATA_W-1:0] mask_q, mask_n;
  logic [TW-1:0]     coal_q, coal_n;
  logic [TW-1:0]     per_q, per_n;
  logic              hp_q, hp_n;

  logic [DATA_W-1:0] clr_bits, set_bits;
  logic              wr_status, wr_enable, wr_timing;
  logic              pending, coal_load, coal_tick, coal_expired;
  logic              per_tick, per_fire, bypass;

  assign wr_status = bus_wr && (bus_addr == WORD_STATUS);
  assign wr_enable = bus_wr && (bus_addr == WORD_ENABLE);
  assign wr_timing = bus_wr && (bus_addr == WORD_TIMING);

  always_comb begin
    set_bits               = evt_in;
    set_bits[BIT_RX_DMA]   = evt_in[BIT_RX_DMA] | hp_rx;
    set_bits[BIT_PERIODIC] = evt_in[BIT_PERIODIC] | per_fire;
    clr_bits               = wr_status ? bus_wdata : '0;
    status_n               = (status_q & ~clr_bits) | set_bits;  // events win
    mask_n                 = wr_enable ? bus_wdata : mask_q;
    coal_n                 = wr_timing ? bus_wdata[TW-1:0] : coal_q;
    per_n                  = wr_timing ? bus_wdata[2*TW-1:TW] : per_q;
    hp_n                   = hp_rx | (hp_q & status_n[BIT_RX_DMA]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      coal_q   <= COAL_RESET;
      per_q    <= '0;
      hp_q     <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      coal_q   <= coal_n;
      per_q    <= per_n;
      hp_q     <= hp_n;
    end
  end

  always_comb begin
    case (bus_addr)
      WORD_STATUS: bus_rdata = status_q;
      WORD_ENABLE: bus_rdata = mask_q;
      WORD_TIMING: bus_rdata = {{PAD_W{1'b0}}, per_q, coal_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign pending = |(status_q & mask_q);
  assign bypass  = hp_q & status_q[BIT_RX_DMA] & mask_q[BIT_RX_DMA];
  assign irq_out = pending & (coal_expired | bypass);

  hic_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_coal_tick (
    .clk(clk), .rst_n(rst_n), .restart(coal_load), .tick(coal_tick)
  );

  hic_coalesce_timer #(.TW(TW)) i_coal (
    .clk(clk), .rst_n(rst_n), .pending(pending), .coal_val(coal_q),
    .tick(coal_tick), .load(coal_load), .expired(coal_expired)
  );

  hic_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_per_tick (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .tick(per_tick)
  );

  hic_periodic #(.TW(TW)) i_per (
    .clk(clk), .rst_n(rst_n), .period(per_q), .tick(per_tick), .fire(per_fire)
  );
endmodule

// File: rtl/hic_checker.sv
module hic_checker
  import hic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] evt_in,
  input logic              hp_rx,
  input logic              irq_out,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q
);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(status_q & mask_q));

  // R9
  hp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_rx && mask_q[BIT_RX_DMA] && !(bus_wr && bus_addr == WORD_ENABLE)) |=> irq_out);

  // R4
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == WORD_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R3
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WORD_STATUS) |=>
      ((status_q & $past(status_q & ~bus_wdata)) == $past(status_q & ~bus_wdata)));
endmodule

bind host_irq_coalescer hic_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_host_irq_coalescer.sv
module test_host_irq_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;
  localparam int NV = 17;

  logic        clk, rst_n, bus_wr, hp_rx;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, evt_in;
  logic        irq_out;
  int          checks = 0, errors = 0, cyc = 0;

  host_irq_coalescer #(.TICK_CYCLES(TICK)) i_host_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .hp_rx(hp_rx), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {op, word, data, expected}: op 0 write, 1 read-check, 2 event pulse
  localparam logic [71:0] VEC [NV] = '{
    {4'd1, 4'd0, 32'h0, 32'h0000_0000},          // R1
    {4'd1, 4'd1, 32'h0, 32'h0000_0000},          // R1
    {4'd1, 4'd2, 32'h0, 32'h0000_0040},          // R1
    {4'd1, 4'd3, 32'h0, 32'h0000_0000},          // R1
    {4'd2, 4'd0, 32'h0000_0009, 32'h0},          // R2
    {4'd1, 4'd0, 32'h0, 32'h0000_0009},
    {4'd0, 4'd0, 32'h0000_0001, 32'h0},          // R3
    {4'd1, 4'd0, 32'h0, 32'h0000_0008},
    {4'd0, 4'd0, 32'h0000_0000, 32'h0},          // R3 zero write
    {4'd1, 4'd0, 32'h0, 32'h0000_0008},
    {4'd2, 4'd0, 32'h0C00_0040, 32'h0},          // R2
    {4'd1, 4'd0, 32'h0, 32'h0C00_0048},
    {4'd0, 4'd0, 32'hFFFF_FFFF, 32'h0},
    {4'd1, 4'd0, 32'h0, 32'h0000_0000},
    {4'd0, 4'd3, 32'hFFFF_FFFF, 32'h0},          // R11
    {4'd1, 4'd3, 32'h0, 32'h0000_0000},
    {4'd1, 4'd2, 32'h0, 32'h0000_0040}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  // After pulse(): edge n must show irq, edge n-1 must not
  task automatic window(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == n - 1) check(req, {31'b0, irq_out}, 32'h0);
      if (i == n)     check(req, {31'b0, irq_out}, 32'h1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c1, c2;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    evt_in = '0; hp_rx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][71:68])
        4'd0: wr(VEC[k][65:64], VEC[k][63:32]);
        4'd1: begin rd(VEC[k][65:64], d); check("R1/R2/R3/R11 table", d, VEC[k][31:0]); end
        default: pulse(VEC[k][63:32]);
      endcase
    end

    // R6 / R8: coalescing window with a mid-window cause
    wr(2'd2, 32'h3); wr(2'd1, 32'h48);
    pulse(32'h8);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      evt_in = (i == 5) ? 32'h40 : 32'h0;
      if (i == 12) check("R8 no restart, R6 before", {31'b0, irq_out}, 32'h0);
      if (i == 13) check("R6 expiry", {31'b0, irq_out}, 32'h1);
    end
    wr(2'd0, 32'h8);
    check("R8 partial clear holds", {31'b0, irq_out}, 32'h1);
    wr(2'd0, 32'h40);
    check("R8 full clear drops", {31'b0, irq_out}, 32'h0);
    pulse(32'h8);
    window(13, "R8 restart full delay");
    wr(2'd0, 32'hFFFF_FFFF);

    // R7: zero coalescing
    wr(2'd2, 32'h0);
    pulse(32'h8);
    check("R7 not same edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 one edge", {31'b0, irq_out}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);

    // R5: disabled cause is ignored until enabled
    wr(2'd1, 32'h8);
    pulse(32'h40);
    repeat (3) @(negedge clk);
    check("R5 disabled", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h48);
    check("R5 enable edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R5 enabled", {31'b0, irq_out}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);

    // R9: bypass vs coalesced bit 31
    wr(2'd2, 32'hFF); wr(2'd1, 32'h8000_0000);
    @(negedge clk); hp_rx = 1'b1;
    @(negedge clk); hp_rx = 1'b0;
    check("R9 bypass irq", {31'b0, irq_out}, 32'h1);
    rd(2'd0, d);
    check("R9 status bit 31", d, 32'h8000_0000);
    wr(2'd0, 32'h8000_0000);
    check("R9 cleared", {31'b0, irq_out}, 32'h0);
    pulse(32'h8000_0000);
    repeat (20) @(negedge clk);
    check("R9 ordinary coalesced", {31'b0, irq_out}, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0);

    // R4: event and clear at the same edge
    pulse(32'h8);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h8; evt_in = 32'h8;
    @(negedge clk); bus_wr = 1'b0; evt_in = '0;
    rd(2'd0, d);
    check("R4 event wins", d, 32'h8);
    wr(2'd0, 32'hFFFF_FFFF);

    // R10: periodic interval 2 ticks
    wr(2'd2, 32'h0200);
    c1 = -1; c2 = -1;
    for (int i = 0; i < 100 && c1 < 0; i++) begin
      @(negedge clk); bus_addr = 2'd0; #1;
      if (bus_rdata[28]) c1 = cyc;
    end
    wr(2'd0, 32'h1000_0000);
    for (int i = 0; i < 100 && c2 < 0; i++) begin
      @(negedge clk); bus_addr = 2'd0; #1;
      if (bus_rdata[28]) c2 = cyc;
    end
    check("R10 period", 32'(c2 - c1), 32'(2 * TICK));
    wr(2'd2, 32'h0); wr(2'd0, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    rd(2'd0, d);
    check("R10 disabled", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule